// File: doc/BRIEF.md
# SDRAM Command Decoder with Full-Page Burst Tracking

This block watches the control side of an SDRAM command bus from the memory's point of view. On every rising clock edge it samples chip select, the three strobes (row, column, write enable), clock enable, the bank-select bits and the address bus. It turns each accepted command into a registered one-hot code, which appears on the outputs one clock after the edge that sampled it.

Alongside decoding, the block follows a single full-page read or write burst. A read or write loads a column counter from the low address bits. The counter then steps once per accepted clock and wraps around the page for as long as the burst runs. Only a burst stop ends the burst, and so does entry into self-refresh. Commands that make no sense in the current state produce a one-cycle illegal pulse. Self-refresh is tracked as a state of its own: the block leaves it only when clock enable returns high.

The block is intended as a protocol monitor or as the front end of a memory model. Data-path latency and mode-register contents are outside its scope.

Top module: `sdram_cmd_tracker`

## Requirements
- R1: While reset is low at a clock edge, every output is zero after that edge: no command bit, no illegal pulse, no burst, column 0, bank 0, write and auto-precharge flags low, and not in self-refresh.
- R2: With chip select low, previous-cycle clock enable high and not in self-refresh, the strobe levels {row, column, write} select the command, and exactly one `cmd_oh` bit is set one clock later. The strobe patterns are 111 NOP (bit 0), 110 burst stop (bit 1), 101 read (bit 2, or bit 3 when A10 is high), 100 write (bit 4, or bit 5 when A10 is high), 011 activate (bit 6), 010 precharge (bit 7, or bit 8 when A10 is high), 001 refresh (bit 9 or 10, see R5) and 000 mode-register set (bit 11).
- R3: A clock with chip select high, or a non-refresh command whose previous-cycle clock enable was low, produces no command bit. The burst state, the column and all flags stay unchanged.
- R4: `cmd_bank` carries the sampled bank bits for activate, precharge, read and write. It is zero for precharge-all, where the bank bits are ignored, and zero for every other command.
- R5: A refresh is accepted whatever the previous clock enable was. The current clock enable decides the type: high gives auto-refresh (bit 9) and low gives self-refresh entry (bit 10).
- R6: After self-refresh entry, `self_refresh` is high and any running burst is cleared. Every command is then ignored, and `cmd_oh` stays zero, until a clock on which clock enable is high. On that clock `self_refresh` falls and the command presented on it is also ignored.
- R7: An accepted read or write sets `burst_active` and loads `burst_col` from address bits [COL_W-1:0]. It also loads `burst_bank` from the bank bits, sets `burst_write` for a write, and sets `burst_autopre` from A10.
- R8: While a burst is active, each accepted clock that neither starts nor stops a burst advances `burst_col` by one. This includes NOP.
- R9: The column counter wraps from PAGE_COLS-1 to 0, so after PAGE_COLS steps it returns to its starting column. The burst carries on without end.
- R10: A burst stop while a burst is active clears `burst_active`. A burst stop with no active burst raises `illegal_cmd`.
- R11: A read or write that arrives while a burst is active raises `illegal_cmd` and also restarts the burst with the new column, bank and flags.
- R12: `illegal_cmd` is high for exactly the one clock that follows an illegal command. It is low after any clock that carries no illegal command.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Command bus clock, sampled on the rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| cs_n | input | 1 | Chip select, active low |
| ras_n | input | 1 | Row strobe, active low |
| cas_n | input | 1 | Column strobe, active low |
| we_n | input | 1 | Write enable, active low |
| cke | input | 1 | Clock enable |
| ba | input | BANK_W | Bank-select bits |
| addr | input | ADDR_W | Address bus; bit AP_BIT is the auto-precharge / all-banks bit |
| cmd_oh | output | 12 | Registered one-hot code of the accepted command |
| cmd_bank | output | BANK_W | Bank that the accepted command addresses |
| illegal_cmd | output | 1 | One-cycle pulse marking an illegal command |
| burst_active | output | 1 | A full-page burst is running |
| burst_col | output | COL_W | Current burst column |
| burst_bank | output | BANK_W | Bank of the current or last burst |
| burst_write | output | 1 | Current or last burst is a write |
| burst_autopre | output | 1 | Current or last burst carries auto-precharge |
| self_refresh | output | 1 | The device is in self-refresh |

## Verification
Two functions can act on the same clock. A read or write that lands during a running burst must raise the illegal pulse and restart the counter at the new column, both in that one cycle. The bench provokes this directly with a write issued in the middle of a wrapping read. The random phase also provokes it often, because read and write make up a quarter of the strobe patterns. A reference model in the bench computes both the pulse and the reloaded column for every cycle and compares them on the same sample. That sample also catches a design that handles only one of the two effects.

// File: rtl/sdcmd_pkg.sv
// Package: shared command kinds for the SDRAM command tracker.
// Assumes the enum value minus one equals the one-hot output bit index.
package sdcmd_pkg;

    localparam int NCMD = 12;

    typedef enum logic [3:0] {
        K_NONE = 4'd0,
        K_NOP  = 4'd1,
        K_BST  = 4'd2,
        K_RD   = 4'd3,
        K_RDA  = 4'd4,
        K_WR   = 4'd5,
        K_WRA  = 4'd6,
        K_ACT  = 4'd7,
        K_PRE  = 4'd8,
        K_PALL = 4'd9,
        K_AREF = 4'd10,
        K_SREF = 4'd11,
        K_MRS  = 4'd12
    } cmd_kind_e;

endpackage

// File: rtl/sdcmd_decode.sv
// Module: sdcmd_decode
// Purely combinational pin decoder. It maps chip select, the three strobes,
// A10 and the current clock enable onto a command kind. It knows no state:
// acceptance rules (previous clock enable, self-refresh) are applied by the top.
module sdcmd_decode
    import sdcmd_pkg::*;
#(
    parameter int ADDR_W = 13,
    parameter int AP_BIT = 10
) (
    input  logic              cs_n,
    input  logic              ras_n,
    input  logic              cas_n,
    input  logic              we_n,
    input  logic              cke,
    input  logic [ADDR_W-1:0] addr,
    output cmd_kind_e         kind
);

    logic ap;
    assign ap = addr[AP_BIT];

    // Strobe pattern to command kind; deselect yields K_NONE.
    always_comb begin
        kind = K_NONE;
        if (!cs_n) begin
            unique case ({ras_n, cas_n, we_n})
                3'b111:  kind = K_NOP;
                3'b110:  kind = K_BST;
                3'b101:  kind = ap ? K_RDA : K_RD;
                3'b100:  kind = ap ? K_WRA : K_WR;
                3'b011:  kind = K_ACT;
                3'b010:  kind = ap ? K_PALL : K_PRE;
                3'b001:  kind = cke ? K_AREF : K_SREF;
                default: kind = K_MRS;
            endcase
        end
    end

endmodule

// File: rtl/sdcmd_burst.sv
// Module: sdcmd_burst
// Full-page burst tracker. A start loads column, bank and flags. An advance
// steps the column modulo PAGE_COLS. A stop clears the active flag and keeps
// the other fields. Start has priority over stop, stop over advance.
module sdcmd_burst #(
    parameter int PAGE_COLS = 256,
    parameter int BANK_W    = 2,
    localparam int COL_W    = $clog2(PAGE_COLS)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic              stop,
    input  logic              adv,
    input  logic [COL_W-1:0]  start_col,
    input  logic [BANK_W-1:0] start_bank,
    input  logic              start_wr,
    input  logic              start_ap,
    output logic              active,
    output logic [COL_W-1:0]  col,
    output logic [BANK_W-1:0] bank,
    output logic              wr,
    output logic              ap
);

    localparam logic [COL_W-1:0] LAST_COL = COL_W'(PAGE_COLS - 1);

    logic [COL_W-1:0] col_next;

    // Next column with wrap at the page end.
    always_comb begin
        col_next = (col == LAST_COL) ? '0 : col + 1'b1;
    end

    // Burst state register: load, stop or step.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            active <= 1'b0;
            col    <= '0;
            bank   <= '0;
            wr     <= 1'b0;
            ap     <= 1'b0;
        end else if (start) begin
            active <= 1'b1;
            col    <= start_col;
            bank   <= start_bank;
            wr     <= start_wr;
            ap     <= start_ap;
        end else if (stop) begin
            active <= 1'b0;
        end else if (adv && active) begin
            col    <= col_next;
        end
    end

    a_r9_page_wrap: assert property (@(posedge clk) disable iff (!rst_n)
        (active && adv && !start && !stop && col == LAST_COL) |=> (col == '0))
        else $error("R9: column did not wrap to zero");

    a_r7_start_sets_active: assert property (@(posedge clk) disable iff (!rst_n)
        start |=> (active && col == $past(start_col)))
        else $error("R7: burst start not captured");

    a_r8_step_by_one: assert property (@(posedge clk) disable iff (!rst_n)
        (active && adv && !start && !stop && col != LAST_COL) |=> (col == $past(col) + 1'b1))
        else $error("R8: column did not step by one");

endmodule

// File: rtl/sdram_cmd_tracker.sv
// Module: sdram_cmd_tracker (top)
// Samples the SDRAM command pins and applies the acceptance rules: previous
// clock enable, the refresh exception and self-refresh. It registers a one-hot
// command code and a bank, flags illegal commands, and drives one full-page
// burst tracker. Assumes COL_W <= AP_BIT, so the column field lies below A10.
module sdram_cmd_tracker
    import sdcmd_pkg::*;
#(
    parameter int PAGE_COLS = 256,
    parameter int BANK_W    = 2,
    parameter int ADDR_W    = 13,
    parameter int AP_BIT    = 10,
    localparam int COL_W    = $clog2(PAGE_COLS)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cs_n,
    input  logic              ras_n,
    input  logic              cas_n,
    input  logic              we_n,
    input  logic              cke,
    input  logic [BANK_W-1:0] ba,
    input  logic [ADDR_W-1:0] addr,
    output logic [NCMD-1:0]   cmd_oh,
    output logic [BANK_W-1:0] cmd_bank,
    output logic              illegal_cmd,
    output logic              burst_active,
    output logic [COL_W-1:0]  burst_col,
    output logic [BANK_W-1:0] burst_bank,
    output logic              burst_write,
    output logic              burst_autopre,
    output logic              self_refresh
);

    cmd_kind_e         kind;
    cmd_kind_e         acc;
    logic              cke_q;
    logic              is_ref;
    logic              accept;
    logic              b_start;
    logic              b_stop;
    logic              b_adv;
    logic              b_wr;
    logic [NCMD-1:0]   oh_d;
    logic [BANK_W-1:0] bank_d;
    logic              illegal_d;

    sdcmd_decode #(
        .ADDR_W (ADDR_W),
        .AP_BIT (AP_BIT)
    ) u_decode (
        .cs_n  (cs_n),
        .ras_n (ras_n),
        .cas_n (cas_n),
        .we_n  (we_n),
        .cke   (cke),
        .addr  (addr),
        .kind  (kind)
    );

    // Acceptance: refresh ignores the previous clock enable, the rest need it.
    always_comb begin
        is_ref = (kind == K_AREF) || (kind == K_SREF);
        accept = (kind != K_NONE) && !self_refresh && (is_ref || cke_q);
        acc    = accept ? kind : K_NONE;
    end

    // Burst control derived from the accepted command.
    always_comb begin
        b_start = (acc == K_RD) || (acc == K_RDA) || (acc == K_WR) || (acc == K_WRA);
        b_wr    = (acc == K_WR) || (acc == K_WRA);
        b_stop  = ((acc == K_BST) && burst_active) || (acc == K_SREF);
        b_adv   = accept && !b_start && !b_stop;
        illegal_d = ((acc == K_BST) && !burst_active) || (b_start && burst_active);
    end

    // One-hot code: bit g marks command kind g+1.
    for (genvar g = 0; g < NCMD; g++) begin : g_onehot
        assign oh_d[g] = (acc == cmd_kind_e'(g + 1));
    end

    // Bank reported for bank-addressed commands only.
    always_comb begin
        unique case (acc)
            K_RD, K_RDA, K_WR, K_WRA, K_ACT, K_PRE: bank_d = ba;
            default:                                bank_d = '0;
        endcase
    end

    // Previous-cycle clock enable.
    always_ff @(posedge clk) begin
        if (!rst_n) cke_q <= 1'b1;
        else        cke_q <= cke;
    end

    // Self-refresh state: entered by an accepted entry, left when cke is high.
    always_ff @(posedge clk) begin
        if (!rst_n)            self_refresh <= 1'b0;
        else if (self_refresh) self_refresh <= !cke;
        else if (acc == K_SREF) self_refresh <= 1'b1;
    end

    // Registered command outputs and the illegal pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cmd_oh      <= '0;
            cmd_bank    <= '0;
            illegal_cmd <= 1'b0;
        end else begin
            cmd_oh      <= oh_d;
            cmd_bank    <= bank_d;
            illegal_cmd <= illegal_d;
        end
    end

    sdcmd_burst #(
        .PAGE_COLS (PAGE_COLS),
        .BANK_W    (BANK_W)
    ) u_burst (
        .clk        (clk),
        .rst_n      (rst_n),
        .start      (b_start),
        .stop       (b_stop),
        .adv        (b_adv),
        .start_col  (addr[COL_W-1:0]),
        .start_bank (ba),
        .start_wr   (b_wr),
        .start_ap   (addr[AP_BIT]),
        .active     (burst_active),
        .col        (burst_col),
        .bank       (burst_bank),
        .wr         (burst_write),
        .ap         (burst_autopre)
    );

    a_r2_onehot: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(cmd_oh))
        else $error("R2: command code not one-hot");

    a_r3_deselect_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (cs_n && !self_refresh) |=> ($stable(burst_col) && $stable(burst_active) && cmd_oh == '0))
        else $error("R3: deselect changed state");

    a_r6_sref_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        self_refresh |=> (cmd_oh == '0 && !illegal_cmd))
        else $error("R6: command accepted in self-refresh");

    a_r10_idle_stop_flagged: assert property (@(posedge clk) disable iff (!rst_n)
        (!cs_n && {ras_n, cas_n, we_n} == 3'b110 && cke_q && !self_refresh && !burst_active)
        |=> illegal_cmd)
        else $error("R10: idle burst stop not flagged");

    a_r11_restart_flagged: assert property (@(posedge clk) disable iff (!rst_n)
        (burst_active && b_start) |=> (illegal_cmd && burst_active))
        else $error("R11: restart not flagged");

endmodule

// File: tb/sdram_cmd_tracker_tb.sv
// Testbench: directed corner cases followed by seeded random stimulus, each
// cycle compared against a reference model written from the requirements.
module sdram_cmd_tracker_tb;

    localparam int CLK_PERIOD = 10;
    localparam int PAGE_COLS  = 256;
    localparam int BANK_W     = 2;
    localparam int ADDR_W     = 13;
    localparam int AP_BIT     = 10;
    localparam int COL_W      = $clog2(PAGE_COLS);
    localparam int NC         = 12;

    logic              clk = 1'b0;
    logic              rst_n;
    logic              cs_n, ras_n, cas_n, we_n, cke;
    logic [BANK_W-1:0] ba;
    logic [ADDR_W-1:0] addr;
    logic [NC-1:0]     cmd_oh;
    logic [BANK_W-1:0] cmd_bank;
    logic              illegal_cmd, burst_active, burst_write, burst_autopre, self_refresh;
    logic [COL_W-1:0]  burst_col;
    logic [BANK_W-1:0] burst_bank;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    // reference model state
    bit              m_sref, m_ckeq, m_act, m_wr, m_ap, e_ill;
    int              m_col;
    logic [BANK_W-1:0] m_bank, e_cbank;
    logic [NC-1:0]   e_cmd;

    always #(CLK_PERIOD/2) clk = ~clk;

    sdram_cmd_tracker #(
        .PAGE_COLS (PAGE_COLS),
        .BANK_W    (BANK_W),
        .ADDR_W    (ADDR_W),
        .AP_BIT    (AP_BIT)
    ) u_dut (
        .clk           (clk),
        .rst_n         (rst_n),
        .cs_n          (cs_n),
        .ras_n         (ras_n),
        .cas_n         (cas_n),
        .we_n          (we_n),
        .cke           (cke),
        .ba            (ba),
        .addr          (addr),
        .cmd_oh        (cmd_oh),
        .cmd_bank      (cmd_bank),
        .illegal_cmd   (illegal_cmd),
        .burst_active  (burst_active),
        .burst_col     (burst_col),
        .burst_bank    (burst_bank),
        .burst_write   (burst_write),
        .burst_autopre (burst_autopre),
        .self_refresh  (self_refresh)
    );

    function automatic int bit_of(logic c, logic r, logic ca, logic w, logic a10, logic ck);
        if (c) return -1;
        case ({r, ca, w})
            3'b111:  return 0;
            3'b110:  return 1;
            3'b101:  return a10 ? 3 : 2;
            3'b100:  return a10 ? 5 : 4;
            3'b011:  return 6;
            3'b010:  return a10 ? 8 : 7;
            3'b001:  return ck ? 9 : 10;
            default: return 11;
        endcase
    endfunction

    // Reference model update for one rising edge.
    task automatic model_step();
        int  k;
        bit  acc, start, stop;
        k     = bit_of(cs_n, ras_n, cas_n, we_n, addr[AP_BIT], cke);
        acc   = (k >= 0) && !m_sref && ((k == 9) || (k == 10) || m_ckeq);
        if (!acc) k = -1;
        e_cmd   = '0;
        if (k >= 0) e_cmd[k] = 1'b1;
        start   = (k >= 2 && k <= 5);
        stop    = (k == 1 && m_act) || (k == 10);
        e_ill   = (k == 1 && !m_act) || (start && m_act);
        e_cbank = ((k >= 2 && k <= 7)) ? ba : '0;
        if (start) begin
            m_act = 1; m_col = int'(addr[COL_W-1:0]); m_bank = ba;
            m_wr = (k == 4 || k == 5); m_ap = addr[AP_BIT];
        end else if (stop) begin
            m_act = 0;
        end else if (acc && m_act) begin
            m_col = (m_col + 1) % PAGE_COLS;
        end
        if (m_sref) m_sref = !cke;
        else if (k == 10) m_sref = 1;
        m_ckeq = cke;
    endtask

    task automatic chk(bit ok, string tag, string what, longint act, longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
        end
    endtask

    task automatic compare_all(string tag);
        chk(cmd_oh == e_cmd, tag, "cmd_oh", cmd_oh, e_cmd);
        chk(cmd_bank == e_cbank, tag, "cmd_bank", cmd_bank, e_cbank);
        chk(illegal_cmd == e_ill, tag, "illegal_cmd", illegal_cmd, e_ill);
        chk(burst_active == m_act, tag, "burst_active", burst_active, m_act);
        chk(int'(burst_col) == m_col, tag, "burst_col", burst_col, m_col);
        chk(burst_bank == m_bank, tag, "burst_bank", burst_bank, m_bank);
        chk(burst_write == m_wr, tag, "burst_write", burst_write, m_wr);
        chk(burst_autopre == m_ap, tag, "burst_autopre", burst_autopre, m_ap);
        chk(self_refresh == m_sref, tag, "self_refresh", self_refresh, m_sref);
    endtask

    // Drive one cycle at the falling edge, step the model, compare at next fall.
    task automatic cyc(logic c, logic [2:0] rcw, logic ck, logic [BANK_W-1:0] b,
                       logic [ADDR_W-1:0] a, string tag);
        cs_n = c; {ras_n, cas_n, we_n} = rcw; cke = ck; ba = b; addr = a;
        @(posedge clk);
        model_step();
        @(negedge clk);
        compare_all(tag);
    endtask

    localparam logic [2:0] P_NOP = 3'b111, P_BST = 3'b110, P_RD = 3'b101, P_WR = 3'b100,
                           P_ACT = 3'b011, P_PRE = 3'b010, P_REF = 3'b001, P_MRS = 3'b000;
    localparam logic [ADDR_W-1:0] A10 = ADDR_W'(1) << AP_BIT;

    initial begin
        rst_n = 1'b0; cs_n = 1'b1; {ras_n, cas_n, we_n} = 3'b111; cke = 1'b1;
        ba = '0; addr = '0;
        m_sref = 0; m_ckeq = 1; m_act = 0; m_wr = 0; m_ap = 0; m_col = 0;
        m_bank = '0; e_cbank = '0; e_cmd = '0; e_ill = 0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        compare_all("R1");
        rst_n = 1'b1;

        cyc(0, P_NOP, 1, 0, 0, "R2");
        cyc(0, P_ACT, 1, 2, 13'h055, "R2");
        cyc(0, P_PRE, 1, 3, 0, "R4");
        cyc(0, P_PRE, 1, 3, A10, "R4");
        cyc(0, P_MRS, 1, 1, 13'h033, "R2");
        cyc(0, P_REF, 1, 1, 0, "R5");
        // R9: read near page end wraps after ten steps
        cyc(0, P_RD, 1, 1, 13'd250, "R7");
        for (int i = 0; i < 10; i++) cyc(0, P_NOP, 1, 0, 0, "R9");
        chk(burst_col == COL_W'(4), "R9", "wrapped column", burst_col, 4);
        // R3: deselect and clock-suspend hold the burst
        for (int i = 0; i < 3; i++) cyc(1, P_RD, 1, 3, 13'h011, "R3");
        cyc(0, P_NOP, 0, 0, 0, "R3");
        cyc(0, P_WR, 1, 2, 13'h022, "R3");
        chk(burst_col == COL_W'(5) && !illegal_cmd, "R3", "suspended column", burst_col, 5);
        // R11: write during burst restarts and flags
        cyc(0, P_WR, 1, 2, A10 | 13'd9, "R11");
        chk(illegal_cmd && burst_col == COL_W'(9) && burst_write, "R11", "restart", burst_col, 9);
        cyc(0, P_NOP, 1, 0, 0, "R12");
        chk(!illegal_cmd, "R12", "pulse width", illegal_cmd, 0);
        // R10: stop, then stop again while idle
        cyc(0, P_BST, 1, 0, 0, "R10");
        chk(!burst_active && !illegal_cmd, "R10", "stop", burst_active, 0);
        cyc(0, P_BST, 1, 0, 0, "R10");
        chk(illegal_cmd, "R10", "idle stop flag", illegal_cmd, 1);
        // R9: a full page of steps returns to the start column
        cyc(0, P_RD, 1, 0, 13'd7, "R8");
        for (int i = 0; i < PAGE_COLS; i++) cyc(0, P_NOP, 1, 0, 0, "R8");
        chk(burst_col == COL_W'(7), "R9", "full page return", burst_col, 7);
        // R6: self-refresh entry clears burst, ignores commands, exits on cke
        cyc(0, P_REF, 0, 0, 0, "R6");
        chk(self_refresh && !burst_active, "R6", "entry", self_refresh, 1);
        cyc(0, P_ACT, 0, 1, 0, "R6");
        cyc(0, P_ACT, 1, 1, 0, "R6");
        chk(!self_refresh && cmd_oh == '0, "R6", "exit", self_refresh, 0);
        cyc(0, P_ACT, 1, 1, 0, "R6");
        // R5: refresh accepted with previous cke low
        cyc(0, P_NOP, 0, 0, 0, "R5");
        cyc(0, P_REF, 1, 0, 0, "R5");
        chk(cmd_oh == NC'(1) << 9, "R5", "auto-refresh", cmd_oh, NC'(1) << 9);

        // random phase
        void'($urandom(32'h5D12_9A07));
        for (int i = 0; i < 4000; i++) begin
            cyc(($urandom % 10) < 2, 3'($urandom), ($urandom % 10) < 9,
                BANK_W'($urandom), ADDR_W'($urandom), "R8");
        end

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

endmodule